// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch Folding

This block sits between an instruction cache and the dispatch stage of a pipeline. On each cycle the cache side offers up to `FILL_N` consecutive instruction words that start at the address on `fetch_pc`. The block writes as many of them as it has room for into a circular queue. It reports how many it took on `fill_taken` and advances `fetch_pc` by that amount. The dispatch side always sees the oldest queued word. Filling carries on while dispatch is stalled, until every slot is in use. When the cache misses, dispatch keeps draining the queue.

A folding unit looks at the two oldest entries for unconditional branches. A word is such a branch when its top six bits equal `110111`. The target is the branch's own address plus the word's low `ADDR_W` bits, taken modulo 2^`ADDR_W`.

- **Branch second oldest:** the oldest entry may dispatch in that same cycle. The branch and every word behind it are dropped, and `fetch_pc` jumps to the target. The branch costs no dispatch slot.
- **Branch at the head:** it is dropped together with the rest of the queue, and the redirect costs one dispatch bubble.

A flush from later stages empties the queue and loads a new fetch address. A flush takes priority over folding.

Back-pressure rules on the fill side:
- `fill_valid` with a nonzero `fill_count` is an offer. It is not a commitment.
- Words beyond `fill_taken` are dropped, and the cache re-offers them from the updated `fetch_pc`.
- `fill_ready` low means nothing will be taken this cycle.

On the dispatch side, a word leaves the queue on any cycle where both `disp_valid` and `disp_ready` are high.

Top module: `prefetch_fold_queue`

## Requirements
- R1: After reset the queue is empty, `disp_valid` is 0, `fill_ready` is 1 and `fetch_pc` equals `RESET_PC`.
- R2: In a cycle without flush or fold, `fill_taken` equals min(`fill_count` clamped to `FILL_N`, free slots), or 0 when `fill_valid` is low. Accepted word i is queued with address `fetch_pc`+i, in order, and `fetch_pc` advances by `fill_taken` at the next edge.
- R3: Entries leave strictly oldest first. `disp_word`/`disp_pc` show the oldest entry whenever `disp_valid` is high, and it is removed on a cycle where `disp_valid` and `disp_ready` are both high.
- R4: While dispatch is stalled, filling continues until `DEPTH` entries are held. When the queue is full, `fill_ready` is 0 and `fill_taken` is 0.
- R5: With `fill_valid` low, every queued non-branch entry is still dispatched.
- R6: With a non-branch oldest entry and a branch (top bits `110111`) second oldest, in that cycle:
  - `fill_taken` is 0;
  - the oldest entry may dispatch;
  - all entries from the branch onward are dropped;
  - `fetch_pc` becomes branch address + low `ADDR_W` bits at the next edge.
- R7: With a branch as oldest entry, in that cycle:
  - `disp_valid` and `fill_taken` are 0;
  - the queue empties;
  - `fetch_pc` becomes its target at the next edge.
- R8: With `flush` high, in that cycle:
  - `disp_valid` and `fill_taken` are 0;
  - the queue empties;
  - `fetch_pc` equals `flush_pc` after the edge, whatever folding would have done.
- R9: A word carrying the branch opcode is never presented with `disp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | output | ADDR_W | Address of the first word the cache should offer |
| fill_valid | input | 1 | Cache offers words this cycle |
| fill_count | input | clog2(FILL_N+1) | Number of words offered (clamped to FILL_N) |
| fill_data | input | FILL_N*DATA_W | Offered words, word i in bits [i*DATA_W +: DATA_W] |
| fill_ready | output | 1 | Queue can take at least one word this cycle |
| fill_taken | output | clog2(FILL_N+1) | Words accepted this cycle |
| disp_valid | output | 1 | Oldest entry is available to dispatch |
| disp_ready | input | 1 | Dispatch takes the presented entry |
| disp_word | output | DATA_W | Oldest queued instruction word |
| disp_pc | output | ADDR_W | Address of that word |
| flush | input | 1 | Empty the queue and restart fetch |
| flush_pc | input | ADDR_W | Restart address used with flush |

## Verification
The following outputs are combinational in the current inputs and queue state, so they are due in the same cycle as the stimulus:
- `fill_taken`;
- `fill_ready`;
- `disp_valid`.

Effects that are due one edge later are:
- a word accepted at an edge appears at the dispatch port just after that edge, at the earliest;
- a fetch-address change from acceptance, folding or flush is visible just after that edge.

The bench drives every input just after a falling edge and checks one time unit later. At that point it compares the same-cycle outputs with a reference queue state held in the bench. It then advances that state by one step, and checks the registered results at the following falling edge. The sweep places branches at two address residues and mixes offers, stalls, misses and rare flushes, so both fold positions, flush-over-fold priority and full-queue back-pressure recur many times.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // opcode in the top six bits of a word that marks an unconditional branch
  localparam logic [5:0] BR_OPCODE = 6'b110111;

  typedef enum logic [1:0] {
    FOLD_NONE  = 2'd0,
    FOLD_HEAD  = 2'd1,
    FOLD_NEXT  = 2'd2,
    FOLD_FLUSH = 2'd3
  } fold_e;
endpackage

// File: rtl/pfq_ring.sv
module pfq_ring #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int FILL_N = 4,
  parameter int DEPTH  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear_all,
  input  logic                              keep_head,
  input  logic                              pop,
  input  logic [$clog2(FILL_N+1)-1:0]       push_cnt,
  input  logic [FILL_N*DATA_W-1:0]          push_data,
  input  logic [ADDR_W-1:0]                 base_pc,
  output logic [DATA_W-1:0]                 head_word,
  output logic [ADDR_W-1:0]                 head_pc,
  output logic [DATA_W-1:0]                 next_word,
  output logic [ADDR_W-1:0]                 next_pc,
  output logic [$clog2(DEPTH+1)-1:0]        count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem_w  [DEPTH];
  logic [ADDR_W-1:0] mem_pc [DEPTH];
  logic [PTR_W-1:0]  head;
  logic [PTR_W-1:0]  tail;
  logic [PTR_W-1:0]  slot [FILL_N];
  logic [DATA_W-1:0] words [FILL_N];

  assign tail = head + count[PTR_W-1:0];

  genvar g;
  generate
    for (g = 0; g < FILL_N; g++) begin : g_lane
      assign words[g] = push_data[g*DATA_W +: DATA_W];
      assign slot[g]  = tail + PTR_W'(g);
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < FILL_N; i++) begin
      if (i < int'(push_cnt)) begin
        mem_w[slot[i]]  <= words[i];
        mem_pc[slot[i]] <= base_pc + ADDR_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else if (clear_all) begin
      count <= '0;
    end else if (keep_head) begin
      head  <= pop ? head + PTR_W'(1) : head;
      count <= pop ? CNT_W'(0) : CNT_W'(1);
    end else begin
      head  <= head + PTR_W'(pop);
      count <= count - CNT_W'(pop) + CNT_W'(push_cnt);
    end
  end

  assign head_word = mem_w[head];
  assign head_pc   = mem_pc[head];
  assign next_word = mem_w[head + PTR_W'(1)];
  assign next_pc   = mem_pc[head + PTR_W'(1)];

  // R4: occupancy never exceeds the storage
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R3: after a plain pop the second oldest becomes the oldest
  assert_oldest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear_all && !keep_head && count >= CNT_W'(2))
      |=> (head_pc == $past(next_pc) && head_word == $past(next_word)));

  // R8 / R7: a clear leaves nothing behind
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> count == '0);
endmodule

// File: rtl/pfq_folder.sv
module pfq_folder
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [5:0]        head_op,
  input  logic [ADDR_W-1:0] head_off,
  input  logic [ADDR_W-1:0] head_pc,
  input  logic [5:0]        next_op,
  input  logic [ADDR_W-1:0] next_off,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              have_head,
  input  logic              have_next,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_pc,
  output fold_e             act,
  output logic [ADDR_W-1:0] redirect_pc
);
  logic head_br, next_br;

  assign head_br = have_head && (head_op == BR_OPCODE);
  assign next_br = have_next && (next_op == BR_OPCODE);

  // priority: flush, then branch at head, then branch second oldest
  always_comb begin
    act         = FOLD_NONE;
    redirect_pc = '0;
    if (flush) begin
      act         = FOLD_FLUSH;
      redirect_pc = flush_pc;
    end else if (head_br) begin
      act         = FOLD_HEAD;
      redirect_pc = head_pc + head_off;
    end else if (next_br) begin
      act         = FOLD_NEXT;
      redirect_pc = next_pc + next_off;
    end
  end
endmodule

// File: rtl/pfq_pc.sv
module pfq_pc #(
  parameter int ADDR_W   = 16,
  parameter int FILL_N   = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        redirect,
  input  logic [ADDR_W-1:0]           redirect_pc,
  input  logic [$clog2(FILL_N+1)-1:0] advance,
  output logic [ADDR_W-1:0]           fetch_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fetch_pc <= RESET_PC;
    else if (redirect) fetch_pc <= redirect_pc;
    else               fetch_pc <= fetch_pc + ADDR_W'(advance);
  end

  // R6: a redirect lands in the fetch address on the next edge
  assert_redirect_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> fetch_pc == $past(redirect_pc));

  // R2: sequential fetch advances by exactly the accepted count
  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> fetch_pc == $past(fetch_pc) + ADDR_W'($past(advance)));
endmodule

// File: rtl/prefetch_fold_queue.sv
module prefetch_fold_queue
  import pfq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int FILL_N = 4,
  parameter int DEPTH  = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic [ADDR_W-1:0]           fetch_pc,
  input  logic                        fill_valid,
  input  logic [$clog2(FILL_N+1)-1:0] fill_count,
  input  logic [FILL_N*DATA_W-1:0]    fill_data,
  output logic                        fill_ready,
  output logic [$clog2(FILL_N+1)-1:0] fill_taken,
  output logic                        disp_valid,
  input  logic                        disp_ready,
  output logic [DATA_W-1:0]           disp_word,
  output logic [ADDR_W-1:0]           disp_pc,
  input  logic                        flush,
  input  logic [ADDR_W-1:0]           flush_pc
);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int TAKE_W = $clog2(FILL_N+1);

  logic [DATA_W-1:0] head_word, next_word;
  logic [ADDR_W-1:0] head_pc, next_pc, redirect_pc;
  logic [CNT_W-1:0]  count;
  fold_e             act;
  logic              pop, clear_all, keep_head, redirect;

  pfq_ring #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILL_N(FILL_N), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .clear_all(clear_all), .keep_head(keep_head), .pop(pop),
    .push_cnt(fill_taken), .push_data(fill_data), .base_pc(fetch_pc),
    .head_word(head_word), .head_pc(head_pc),
    .next_word(next_word), .next_pc(next_pc), .count(count)
  );

  pfq_folder #(.ADDR_W(ADDR_W)) u_fold (
    .head_op(head_word[DATA_W-1 -: 6]), .head_off(head_word[ADDR_W-1:0]), .head_pc(head_pc),
    .next_op(next_word[DATA_W-1 -: 6]), .next_off(next_word[ADDR_W-1:0]), .next_pc(next_pc),
    .have_head(count >= CNT_W'(1)), .have_next(count >= CNT_W'(2)),
    .flush(flush), .flush_pc(flush_pc),
    .act(act), .redirect_pc(redirect_pc)
  );

  pfq_pc #(.ADDR_W(ADDR_W), .FILL_N(FILL_N), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_pc(redirect_pc),
    .advance(fill_taken), .fetch_pc(fetch_pc)
  );

  assign clear_all = (act == FOLD_FLUSH) || (act == FOLD_HEAD);
  assign keep_head = (act == FOLD_NEXT);
  assign redirect  = (act != FOLD_NONE);

  assign disp_valid = (count != '0) && !clear_all;
  assign disp_word  = head_word;
  assign disp_pc    = head_pc;
  assign pop        = disp_valid && disp_ready;

  assign fill_ready = (act == FOLD_NONE) && (count != CNT_W'(DEPTH));

  always_comb begin
    int offered, free_slots, take;
    offered    = fill_valid ? ((int'(fill_count) > FILL_N) ? FILL_N : int'(fill_count)) : 0;
    free_slots = DEPTH - int'(count);
    take       = (offered > free_slots) ? free_slots : offered;
    fill_taken = (act == FOLD_NONE) ? TAKE_W'(take) : '0;
  end

  // R2: acceptance never exceeds the free space
  assert_take_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_taken) + int'(count) <= DEPTH);

  // R8: a flush cycle neither dispatches nor accepts
  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (fill_taken == '0 && !disp_valid));

  // R9: branch words are never offered to dispatch
  assert_branch_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_word[DATA_W-1 -: 6] != BR_OPCODE));

  // R7: a head fold leaves the queue empty
  assert_head_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == FOLD_HEAD) |=> !disp_valid || flush || fill_taken != '0 || count == '0);
endmodule

// File: tb/prefetch_fold_queue_test.sv
module prefetch_fold_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int FN = 2;
  localparam int DEP = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] fetch_pc;
  logic fill_valid = 0;
  logic [1:0] fill_count = 0;
  logic [FN*DW-1:0] fill_data = '0;
  logic fill_ready;
  logic [1:0] fill_taken;
  logic disp_valid;
  logic disp_ready = 0;
  logic [DW-1:0] disp_word;
  logic [AW-1:0] disp_pc;
  logic flush = 0;
  logic [AW-1:0] flush_pc = '0;

  int n_chk = 0, n_fail = 0, n_disp = 0;
  logic [DW-1:0] m_w  [8];
  logic [AW-1:0] m_pc [8];
  int m_cnt = 0;
  logic [AW-1:0] m_fpc = '0;
  string pc_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_fold_queue #(.DATA_W(DW), .ADDR_W(AW), .FILL_N(FN), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .fill_valid(fill_valid), .fill_count(fill_count), .fill_data(fill_data),
    .fill_ready(fill_ready), .fill_taken(fill_taken),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_word(disp_word), .disp_pc(disp_pc),
    .flush(flush), .flush_pc(flush_pc)
  );

  // program image: branches at address residues 5 (+0x13) and 11 (-7)
  function automatic logic [DW-1:0] prog(input logic [AW-1:0] a);
    if (a[3:0] == 4'd5)  return {6'b110111, 10'h0, 16'h0013};
    if (a[3:0] == 4'd11) return {6'b110111, 10'h0, 16'hFFF9};
    return {6'h01, 10'h0, a};
  endfunction

  function automatic bit isbr(input logic [DW-1:0] w);
    return w[31:26] == 6'b110111;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step(input bit fv, input int fc, input bit dr, input bit fl, input logic [AW-1:0] fpc_in);
    logic [FN*DW-1:0] fd;
    int free_s, offr, take;
    bit hb0, hb1, ev, pop;
    string ttag;
    @(negedge clk);
    fd = '0;
    for (int i = 0; i < FN; i++) fd[i*DW +: DW] = prog(m_fpc + AW'(i));
    fill_valid = fv; fill_count = 2'(fc); fill_data = fd;
    disp_ready = dr; flush = fl; flush_pc = fpc_in;
    #1;
    chk(pc_tag, "fetch_pc", 32'(fetch_pc), 32'(m_fpc));
    free_s = DEP - m_cnt;
    hb0 = (m_cnt >= 1) && isbr(m_w[0]);
    hb1 = (m_cnt >= 2) && !hb0 && isbr(m_w[1]);
    ev  = (m_cnt > 0) && !hb0 && !fl;
    offr = fv ? ((fc > FN) ? FN : fc) : 0;
    take = (fl || hb0 || hb1) ? 0 : ((offr > free_s) ? free_s : offr);
    ttag = fl ? "R8" : hb0 ? "R7" : hb1 ? "R6" : (free_s == 0) ? "R4" : "R2";
    chk(fl ? "R8" : hb0 ? "R7" : "R3", "disp_valid", 32'(disp_valid), 32'(ev));
    if (ev) begin
      chk("R3", "disp_word", disp_word, m_w[0]);
      chk("R3", "disp_pc", 32'(disp_pc), 32'(m_pc[0]));
    end
    if (disp_valid) chk("R9", "branch at dispatch", 32'(isbr(disp_word)), 0);
    chk(ttag, "fill_taken", 32'(fill_taken), 32'(take));
    chk(ttag, "fill_ready", 32'(fill_ready), 32'(!fl && !hb0 && !hb1 && free_s > 0));
    if (disp_valid && dr) n_disp++;
    pop = ev && dr;
    if (fl) begin
      m_cnt = 0; m_fpc = fpc_in; pc_tag = "R8";
    end else if (hb0) begin
      m_fpc = m_pc[0] + m_w[0][AW-1:0]; m_cnt = 0; pc_tag = "R7";
    end else if (hb1) begin
      m_fpc = m_pc[1] + m_w[1][AW-1:0]; m_cnt = pop ? 0 : 1; pc_tag = "R6";
    end else begin
      if (pop) begin
        for (int i = 0; i < 7; i++) begin m_w[i] = m_w[i+1]; m_pc[i] = m_pc[i+1]; end
        m_cnt--;
      end
      for (int i = 0; i < take; i++) begin
        m_w[m_cnt] = prog(m_fpc + AW'(i)); m_pc[m_cnt] = m_fpc + AW'(i); m_cnt++;
      end
      m_fpc = m_fpc + AW'(take); pc_tag = "R2";
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    int d0;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset fetch_pc", 32'(fetch_pc), 0);
    chk("R1", "reset disp_valid", 32'(disp_valid), 0);
    chk("R1", "reset fill_ready", 32'(fill_ready), 1);
    rst_n = 1;

    // R4: fill while dispatch stalled, from 0x100 (no branches in 0x100..0x104)
    step(0, 0, 0, 1, 16'h0100);
    for (int k = 0; k < 4; k++) step(1, 2, 0, 0, 0);
    // R5: cache misses, dispatch drains the queue
    d0 = n_disp;
    for (int k = 0; k < 6; k++) step(0, 0, 1, 0, 0);
    chk("R5", "words dispatched during miss", 32'(n_disp - d0), 4);

    // R6: branch second oldest folds with no dispatch bubble
    step(0, 0, 1, 1, 16'h0104);
    step(1, 2, 1, 0, 0);
    d0 = n_disp;
    step(1, 2, 1, 0, 0);
    chk("R6", "oldest dispatched during fold", 32'(n_disp - d0), 1);
    step(0, 0, 1, 0, 0);
    chk("R6", "redirect target", 32'(fetch_pc), 32'h0118);

    // R7: branch at head
    step(0, 0, 1, 1, 16'h0105);
    step(1, 2, 1, 0, 0);
    step(1, 2, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R7", "head fold target", 32'(fetch_pc), 32'h0118);

    // R8: flush wins over a pending head fold
    step(0, 0, 1, 1, 16'h0105);
    step(1, 2, 1, 0, 0);
    step(1, 2, 1, 1, 16'h0300);
    step(0, 0, 0, 0, 0);
    chk("R8", "flush beats fold", 32'(fetch_pc), 32'h0300);

    // sweep: offers incl. over-count (3 > FILL_N), stalls, misses, rare flushes
    r = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      r = r * 32'd1103515245 + 32'd12345;
      step(r[20] | r[21], int'(r[23:22]), r[24] | r[25], r[31:27] == 5'd0, r[15:0]);
    end

    report();
    $finish;
  end
endmodule